// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the speed of up to four fans (three by default) by counting reference ticks between successive rising edges of each fan's tachometer signal. Each tachometer input first passes through a synchronizer and a rising-edge detector. A 12-bit counter for each fan advances on every clock that has the tick enable high. At each detected edge the finished period is stored in the fan's count register and the counter starts again from zero. A fan that stops produces no edges, so its counter climbs to 0xFFF and holds there, and the count register then shows 0xFFF to mark a stalled fan. Software converts a count to rpm as 1,500,000 / count.

Each fan has a 12-bit low-speed limit. The block raises that fan's alarm while the measured count is larger than the limit, which means the fan is turning slower than allowed. A limit of 0xFFF therefore silences the alarm. A per-fan disable bit freezes the measurement at zero and masks the alarm.

All values are reached through a byte-wide register port. A 12-bit value occupies two bytes: the high byte at the even address and the low byte at the following address. Reading the high byte of a count also captures the low byte into a holding register, so a later low-byte read returns half of the same sample even if a new period has completed in between.

Top module: `fan_tach_mon`

## Requirements
- R1: While a fan is enabled, its count equals the number of clocks with `tick` high, taken over the window from the cycle after one detected tach rising edge up to and including the cycle of the next detected edge.
- R2: When the running counter of an enabled fan reaches 0xFFF with no tach edge, it stops there and the count register is forced to 0xFFF.
- R3: Fan n's count reads as a high byte at address 0x20+2n and a low byte at 0x21+2n. Bits 7:4 of the high byte always read 0.
- R4: Reading a count high byte copies the low 8 bits of that same count into a per-fan holding register. A read at 0x21+2n returns the holding register, not the live count.
- R5: Fan n's low limit is at 0x28+2n (high byte) and 0x29+2n (low byte). Writes to the high byte store only bits 3:0, and bits 7:4 read back as 0.
- R6: `fan_alarm[n]` is 1 exactly when fan n is enabled and its count is strictly greater than its limit.
- R7: A limit of 0xFFF keeps the alarm at 0 for every count, including a stalled fan.
- R8: Bit 7 of the control byte at 0x60+16n disables fan n. Its count is cleared and held at 0, tach pulses are ignored and the alarm stays 0. Reads of the control byte return the disable bit in bit 7 and 0 in bits 6:0.
- R9: After reset every count reads 0, every limit reads 0xFFF, every fan is enabled and every alarm is 0.
- R10: Read data appears on `bus_rdata` in the clock after the one in which `bus_rd` is sampled high. An address that maps to nothing reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Reference tick enable for the period counters |
| tach | input | NUM_FANS | Raw tachometer inputs, one per fan |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| fan_alarm | output | NUM_FANS | Per-fan low-speed alarm |

## Verification
The bench measures periods on each fan against limits below, equal to and above the count. An off-by-one in the window would show up as a count of P-1 or P+1, and a greater-or-equal compare would raise the alarm at equality. It splits a count read around a fresh measurement: a design without the holding register would mix the low byte of the new period with the high byte of the old one. It also lets a fan stall until the counter saturates, which exposes a design whose counter wraps or that keeps the last good period. Finally it disables a fan that is in alarm and pulses it, which catches a design that keeps counting or leaves the alarm raised.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    localparam int CNT_W     = 12;
    localparam int MAX_FANS  = 4;
    localparam int IDX_W     = 2;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // register map anchors
    localparam logic [7:0] CNT_BASE   = 8'h20;
    localparam logic [7:0] LIM_BASE   = 8'h28;
    localparam logic [7:0] CTL_BASE   = 8'h60;
    localparam int         CTL_STRIDE = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        F_NONE,
        F_CNT_HI,
        F_CNT_LO,
        F_LIM_HI,
        F_LIM_LO,
        F_CTL
    } field_e;

    typedef struct packed {
        field_e             kind;
        logic [IDX_W-1:0]   idx;
    } decode_t;

    // saturating increment
    function automatic cnt_t sat_add(cnt_t v, logic inc);
        if (inc && (v != CNT_MAX))
            return v + 1'b1;
        return v;
    endfunction

    // map a byte address onto a field and fan index
    function automatic decode_t decode_addr(logic [7:0] a, int nfans);
        decode_t d;
        d.kind = F_NONE;
        d.idx  = '0;
        for (int i = 0; i < nfans; i++) begin
            if (a == CNT_BASE + 8'(2*i)) begin
                d.kind = F_CNT_HI; d.idx = IDX_W'(i);
            end else if (a == CNT_BASE + 8'(2*i + 1)) begin
                d.kind = F_CNT_LO; d.idx = IDX_W'(i);
            end else if (a == LIM_BASE + 8'(2*i)) begin
                d.kind = F_LIM_HI; d.idx = IDX_W'(i);
            end else if (a == LIM_BASE + 8'(2*i + 1)) begin
                d.kind = F_LIM_LO; d.idx = IDX_W'(i);
            end else if (a == CTL_BASE + 8'(CTL_STRIDE*i)) begin
                d.kind = F_CTL; d.idx = IDX_W'(i);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/fan_period_ch.sv
module fan_period_ch
    import fan_tach_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic tach_raw,
    input  logic fan_off,
    input  cnt_t limit,
    output cnt_t period,
    output logic alarm
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   tach_prev;
    logic                   rise;
    cnt_t                   run_q;
    cnt_t                   run_nxt;

    // synchronizer and edge history
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= '0;
            tach_prev <= 1'b0;
        end else begin
            sync_q    <= {sync_q[SYNC_STAGES-2:0], tach_raw};
            tach_prev <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise    = sync_q[SYNC_STAGES-1] & ~tach_prev;
    assign run_nxt = sat_add(run_q, tick);

    // period counter, result register, stall marking
    always_ff @(posedge clk) begin
        if (rst || fan_off) begin
            run_q  <= '0;
            period <= '0;
        end else if (rise) begin
            period <= run_nxt;
            run_q  <= '0;
        end else begin
            run_q <= run_nxt;
            if (run_nxt == CNT_MAX)
                period <= CNT_MAX;
        end
    end

    assign alarm = ~fan_off & (period > limit);

endmodule

// File: rtl/fan_regs.sv
module fan_regs
    import fan_tach_pkg::*;
#(
    parameter int N = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    input  cnt_t [N-1:0]     period_i,
    output logic [7:0]       rdata,
    output cnt_t [N-1:0]     limit_o,
    output logic [N-1:0]     off_o
);

    localparam int HI_W = CNT_W - 8;

    decode_t              dec;
    logic [N-1:0][7:0]    shadow_q;

    assign dec = decode_addr(addr, N);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= '0;
            shadow_q <= '0;
            off_o    <= '0;
            for (int i = 0; i < N; i++)
                limit_o[i] <= CNT_MAX;
        end else begin
            if (wr_en) begin
                case (dec.kind)
                    F_LIM_HI: limit_o[dec.idx][CNT_W-1:8] <= wdata[HI_W-1:0];
                    F_LIM_LO: limit_o[dec.idx][7:0]       <= wdata;
                    F_CTL:    off_o[dec.idx]              <= wdata[7];
                    default: ;
                endcase
            end
            if (rd_en) begin
                case (dec.kind)
                    F_CNT_HI: begin
                        rdata            <= 8'(period_i[dec.idx][CNT_W-1:8]);
                        shadow_q[dec.idx] <= period_i[dec.idx][7:0];
                    end
                    F_CNT_LO: rdata <= shadow_q[dec.idx];
                    F_LIM_HI: rdata <= 8'(limit_o[dec.idx][CNT_W-1:8]);
                    F_LIM_LO: rdata <= limit_o[dec.idx][7:0];
                    F_CTL:    rdata <= {off_o[dec.idx], 7'b0};
                    default:  rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/fan_tach_mon.sv
module fan_tach_mon
    import fan_tach_pkg::*;
#(
    parameter int NUM_FANS    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [NUM_FANS-1:0] tach,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [7:0]          bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    output logic [NUM_FANS-1:0] fan_alarm
);

    cnt_t [NUM_FANS-1:0] period_q;
    cnt_t [NUM_FANS-1:0] limit_q;
    logic [NUM_FANS-1:0] off_q;

    fan_regs #(.N(NUM_FANS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .period_i (period_q),
        .rdata    (bus_rdata),
        .limit_o  (limit_q),
        .off_o    (off_q)
    );

    for (genvar g = 0; g < NUM_FANS; g++) begin : g_fan
        fan_period_ch #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .tach_raw (tach[g]),
            .fan_off  (off_q[g]),
            .limit    (limit_q[g]),
            .period   (period_q[g]),
            .alarm    (fan_alarm[g])
        );
    end

endmodule

// File: rtl/fan_tach_chk.sv
module fan_tach_chk
    import fan_tach_pkg::*;
#(
    parameter int N = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_rd,
    input logic [7:0]       bus_addr,
    input logic [7:0]       bus_rdata,
    input logic [N-1:0]     fan_alarm,
    input logic [N-1:0]     off_q,
    input cnt_t [N-1:0]     limit_q,
    input cnt_t [N-1:0]     period_q
);

    for (genvar i = 0; i < N; i++) begin : g_chk
        localparam logic [7:0] HI_A = CNT_BASE + 8'(2*i);

        // R8
        off_blocks_chk: assert property (@(posedge clk) disable iff (rst)
            off_q[i] |=> (period_q[i] == '0) && !fan_alarm[i]);

        // R7
        lim_max_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (limit_q[i] == CNT_MAX) |-> !fan_alarm[i]);

        // R6
        alarm_slow_chk: assert property (@(posedge clk) disable iff (rst)
            fan_alarm[i] |-> (period_q[i] != '0) && !off_q[i]);

        // R2
        stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (period_q[i] == CNT_MAX) && !off_q[i] && $stable(period_q[i])
                |-> (period_q[i] > limit_q[i]) == fan_alarm[i]);

        // R3
        hi_nibble_chk: assert property (@(posedge clk) disable iff (rst)
            bus_rd && (bus_addr == HI_A) |=> (bus_rdata[7:4] == 4'h0));
    end

endmodule

bind fan_tach_mon fan_tach_chk #(.N(NUM_FANS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .fan_alarm (fan_alarm),
    .off_q     (off_q),
    .limit_q   (limit_q),
    .period_q  (period_q)
);

// File: tb/test_fan_tach_mon.sv
`timescale 1ns/1ps
module test_fan_tach_mon;

    localparam int NF = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          tick;
    logic          tick_alt;
    logic [NF-1:0] tach;
    logic          bus_wr, bus_rd;
    logic [7:0]    bus_addr, bus_wdata;
    logic [7:0]    bus_rdata;
    logic [NF-1:0] fan_alarm;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    fan_tach_mon #(.NUM_FANS(NF)) i_fan_tach_mon (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .tach      (tach),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .fan_alarm (fan_alarm)
    );

    always @(negedge clk) tick <= tick_alt ? ~tick : 1'b1;

    // columns: fan, period, limit, expected alarm
    localparam int NV = 5;
    localparam int VEC [NV][4] = '{
        '{0,  100,  200, 0},
        '{1,  300,  200, 1},
        '{2,   50,   50, 0},
        '{0,   51,   50, 1},
        '{1, 1000, 4095, 0}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input int f);
        tach[f] = 1'b1;
        @(negedge clk);
        tach[f] = 1'b0;
    endtask

    task automatic measure(input int f, input int p);
        pulse(f);
        repeat (p - 1) @(negedge clk);
        pulse(f);
        repeat (4) @(negedge clk);
    endtask

    task automatic rd(input int a, output int v);
        bus_rd   = 1'b1;
        bus_addr = 8'(a);
        @(negedge clk);
        v      = int'(bus_rdata);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        bus_wr    = 1'b1;
        bus_addr  = 8'(a);
        bus_wdata = 8'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_pair(input int a, output int v);
        int h, l;
        rd(a, h);
        rd(a + 1, l);
        v = (h << 8) | l;
    endtask

    task automatic set_limit(input int f, input int v);
        wr(8'h28 + 2*f, v >> 8);
        wr(8'h29 + 2*f, v & 8'hFF);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v;
        rst = 1'b1; tick_alt = 1'b0; tach = '0;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        for (int f = 0; f < NF; f++) begin
            rd_pair(8'h20 + 2*f, v); chk("R9 count after reset", v, 0);
            rd_pair(8'h28 + 2*f, v); chk("R9 limit after reset", v, 12'hFFF);
            rd(8'h60 + 16*f, v);     chk("R9 control after reset", v, 0);
        end
        chk("R9 alarms after reset", int'(fan_alarm), 0);

        // R1 and R6 vector table
        for (int k = 0; k < NV; k++) begin
            set_limit(VEC[k][0], VEC[k][2]);
            measure(VEC[k][0], VEC[k][1]);
            chk("R6 alarm vs limit", int'(fan_alarm[VEC[k][0]]), VEC[k][3]);
            rd_pair(8'h20 + 2*VEC[k][0], v);
            chk("R1 measured period", v, VEC[k][1]);
        end

        // R4 coherent two-byte read
        measure(2, 300);
        rd(8'h24, v);           chk("R4 high byte of first sample", v, 8'h01);
        measure(2, 500);
        rd(8'h25, v);           chk("R4 low byte held from first sample", v, 8'h2C);
        rd_pair(8'h24, v);      chk("R4 fresh pair after new read", v, 12'h1F4);

        // R5 limit byte layout
        wr(8'h28, 8'hFF);
        wr(8'h29, 8'h34);
        rd(8'h28, v);           chk("R5 limit high nibble masked", v, 8'h0F);
        rd(8'h29, v);           chk("R5 limit low byte", v, 8'h34);

        // R8 disable
        set_limit(1, 200);
        measure(1, 300);
        chk("R8 alarm before disable", int'(fan_alarm[1]), 1);
        wr(8'h70, 8'hFF);
        repeat (2) @(negedge clk);
        chk("R8 alarm masked when off", int'(fan_alarm[1]), 0);
        rd(8'h70, v);           chk("R8 control readback", v, 8'h80);
        rd_pair(8'h22, v);      chk("R8 count cleared when off", v, 0);
        measure(1, 100);
        rd_pair(8'h22, v);      chk("R8 pulses ignored when off", v, 0);
        chk("R8 alarm stays low when off", int'(fan_alarm[1]), 0);
        wr(8'h70, 8'h00);
        measure(1, 100);
        rd_pair(8'h22, v);      chk("R8 measures again after enable", v, 100);

        // R2 stall saturation, R3 high nibble, R7 silent limit
        set_limit(0, 12'h0FF);
        repeat (4200) @(negedge clk);
        rd(8'h20, v);           chk("R3 high byte of stalled count", v, 8'h0F);
        rd(8'h21, v);           chk("R2 low byte of stalled count", v, 8'hFF);
        chk("R2 stalled fan raises alarm", int'(fan_alarm[0]), 1);
        set_limit(0, 12'hFFF);
        chk("R7 limit 0xFFF silences stalled fan", int'(fan_alarm[0]), 0);

        // R1 tick gating: every other clock
        tick_alt = 1'b1;
        measure(2, 200);
        tick_alt = 1'b0;
        rd_pair(8'h24, v);      chk("R1 half-rate tick period", v, 100);

        // R10 unmapped address
        rd(8'h30, v);           chk("R10 unmapped read is zero", v, 0);
        rd(8'h62, v);           chk("R10 near-control unmapped read", v, 0);

        finish_run();
    end

endmodule